// File: doc/BRIEF.md
# Post-Commit Store Queue with Load Forwarding

This block sits between the commit stage and the L1 data cache write port. Each store that retires is put in a small FIFO with its word address, its data and its byte enables. No store writes the cache directly, not even one that hits. Every cache update leaves this queue through one write port, oldest store first, under a valid/ready handshake. Because the queue only accepts stores that have already committed, nothing it writes can come from a speculative instruction.

Loads probe the queue in the same cycle that they probe the cache. For each requested byte lane, the queue returns the byte from the youngest pending store to the same word address that enables that lane. If the queue supplies every requested byte, the load can take the forwarded word. If it supplies only some of them, the load is told to stall until the store drains. If it supplies none, the cache data is correct as it stands.

A store presented in a cycle becomes visible to lookups from the next cycle on. The queue depth must be a power of two. Byte lane k is data bits 8k+7 down to 8k, and it is governed by enable bit k.

Top module: `commit_store_queue`

## Requirements
- R1: After reset the queue is empty. bufEmpty=1, bufFull=0, enqReady=1, wrValid=0.
- R2: A store is accepted on a cycle with enqValid=1 and enqReady=1. enqReady is 0 whenever DEPTH (default 8) stores are held, and bufFull is 1 exactly then.
- R3: While the queue holds a store, wrValid=1 and wrAddr/wrData/wrBe show the oldest store. A cycle with wrValid=1 and wrReady=1 removes it. Every accepted store is written exactly once, in acceptance order.
- R4: While wrValid=1 and wrReady=0, the write port's address, data and enables stay unchanged.
- R5: A store presented while enqReady=0 is ignored. It never appears on the write port, and it does not change the occupancy.
- R6: On a lookup (ldValid=1), fwdMask bit k is 1 when requested lane k (ldBe bit k) is enabled in a pending store to ldAddr. fwdData lane k then holds that byte from the youngest such store. Lanes that are not supplied read as 0.
- R7: ldStall=1 when a lookup is supplied some but not all of its requested lanes. fwdHit=1 only when all requested lanes (a nonzero ldBe) are supplied. ldStall and fwdHit are never both 1.
- R8: A lookup with no matching lane, or with ldValid=0, gives fwdMask=0, fwdData=0, fwdHit=0 and ldStall=0.
- R9: A cycle that both accepts and drains a store leaves the occupancy, bufFull and bufEmpty unchanged.
- R10: bufEmpty=1 exactly when no store is held. While empty, wrValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Commit stage presents a retired store |
| enqAddr | input | 32 | Word address of the store |
| enqData | input | 32 | Store data, four byte lanes |
| enqBe | input | 4 | Byte enables of the store |
| enqReady | output | 1 | Queue can accept a store this cycle |
| ldValid | input | 1 | Load lookup request |
| ldAddr | input | 32 | Word address of the load |
| ldBe | input | 4 | Byte lanes the load needs |
| fwdData | output | 32 | Forwarded bytes, zero in lanes not supplied |
| fwdMask | output | 4 | Lanes supplied by the queue |
| fwdHit | output | 1 | All requested lanes supplied |
| ldStall | output | 1 | Partial overlap; the load must wait |
| wrValid | output | 1 | Cache write request for the oldest store |
| wrReady | input | 1 | Cache accepts the write this cycle |
| wrAddr | output | 32 | Cache write word address |
| wrData | output | 32 | Cache write data |
| wrBe | output | 4 | Cache write byte enables |
| bufFull | output | 1 | Queue holds DEPTH stores |
| bufEmpty | output | 1 | Queue holds no store |

## Verification
The assertions assume that reset is held low for at least one clock before any traffic. They also assume that the cache side is free to hold wrReady low for any number of cycles. The commit side may raise enqValid while the queue is full, and the checks expect that request to be dropped, not treated as an error. The stimulus changes all inputs only on the falling clock edge and holds wrReady low while it fills the queue. This makes the order of pending stores, and so the youngest-wins result on each lane, fixed and known in advance. It then releases wrReady one cycle at a time, so that each drain and each simultaneous accept and drain can be predicted exactly.

// File: rtl/stq_pkg.sv
package stq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } stqStrobe_t;
endpackage

// File: rtl/stq_control.sv
module stq_control
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enqValid,
  input  logic            wrReady,
  output logic            enqReady,
  output logic            wrValid,
  output logic            bufFull,
  output logic            bufEmpty,
  output stqStrobe_t      strobe,
  output logic [PTRW-1:0] headIdx,
  output logic [PTRW-1:0] tailIdx,
  output logic [CNTW-1:0] count
);
  assign bufFull  = (count == CNTW'(DEPTH));
  assign bufEmpty = (count == '0);
  assign enqReady = !bufFull;
  assign wrValid  = !bufEmpty;

  assign strobe.push = enqValid && enqReady;
  assign strobe.pop  = wrValid && wrReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else begin
      if (strobe.push) tailIdx <= tailIdx + PTRW'(1);
      if (strobe.pop)  headIdx <= headIdx + PTRW'(1);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNTW'(DEPTH) && !wrReady) |=> (count == CNTW'(DEPTH)) && !enqReady);
  // R4
  drain_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid);
  // R9
  pushpop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop) |=> $stable(count));
  // R10
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && count == CNTW'(1) && !strobe.push) |=> !wrValid);
endmodule

// File: rtl/stq_datapath.sv
module stq_datapath
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTRW  = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stqStrobe_t       strobe,
  input  logic [PTRW-1:0]  headIdx,
  input  logic [PTRW-1:0]  tailIdx,
  input  logic [CNTW-1:0]  count,
  input  logic [AW-1:0]    enqAddr,
  input  logic [DW-1:0]    enqData,
  input  logic [LANES-1:0] enqBe,
  input  logic             ldValid,
  input  logic [AW-1:0]    ldAddr,
  input  logic [LANES-1:0] ldBe,
  output logic [DW-1:0]    fwdData,
  output logic [LANES-1:0] fwdMask,
  output logic             fwdHit,
  output logic             ldStall,
  output logic [AW-1:0]    wrAddr,
  output logic [DW-1:0]    wrData,
  output logic [LANES-1:0] wrBe
);
  logic [AW-1:0]    slotAddr [DEPTH];
  logic [DW-1:0]    slotData [DEPTH];
  logic [LANES-1:0] slotBe   [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[s] <= '0;
        slotData[s] <= '0;
        slotBe[s]   <= '0;
      end else if (strobe.push && tailIdx == PTRW'(s)) begin
        slotAddr[s] <= enqAddr;
        slotData[s] <= enqData;
        slotBe[s]   <= enqBe;
      end
    end
  end

  assign wrAddr = slotAddr[headIdx];
  assign wrData = slotData[headIdx];
  assign wrBe   = slotBe[headIdx];

  // Scan oldest to youngest; a later match overwrites the lane
  logic [LANES-1:0] laneFound;
  logic [DW-1:0]    laneBytes;
  always_comb begin
    laneFound = '0;
    laneBytes = '0;
    for (int age = 0; age < DEPTH; age++) begin
      logic [PTRW-1:0] idx;
      idx = headIdx + PTRW'(age);
      if (CNTW'(age) < count && slotAddr[idx] == ldAddr) begin
        for (int b = 0; b < LANES; b++) begin
          if (slotBe[idx][b]) begin
            laneFound[b]       = 1'b1;
            laneBytes[8*b +: 8] = slotData[idx][8*b +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    fwdMask = ldValid ? (laneFound & ldBe) : '0;
    for (int b = 0; b < LANES; b++)
      fwdData[8*b +: 8] = fwdMask[b] ? laneBytes[8*b +: 8] : 8'h00;
    fwdHit  = ldValid && (ldBe != '0) && (fwdMask == ldBe);
    ldStall = ldValid && (fwdMask != '0) && (fwdMask != ldBe);
  end

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0 && !strobe.pop) |=> ($stable(wrAddr) && $stable(wrData) && $stable(wrBe)));
  // R6
  mask_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdMask & ~ldBe) == '0);
  // R7
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ldStall && fwdHit));
  // R8
  idle_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |-> (fwdMask == '0 && fwdData == '0 && !fwdHit && !ldStall));
endmodule

// File: rtl/commit_store_queue.sv
module commit_store_queue
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTRW  = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enqValid,
  input  logic [AW-1:0]    enqAddr,
  input  logic [DW-1:0]    enqData,
  input  logic [LANES-1:0] enqBe,
  output logic             enqReady,
  input  logic             ldValid,
  input  logic [AW-1:0]    ldAddr,
  input  logic [LANES-1:0] ldBe,
  output logic [DW-1:0]    fwdData,
  output logic [LANES-1:0] fwdMask,
  output logic             fwdHit,
  output logic             ldStall,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [AW-1:0]    wrAddr,
  output logic [DW-1:0]    wrData,
  output logic [LANES-1:0] wrBe,
  output logic             bufFull,
  output logic             bufEmpty
);
  stqStrobe_t      strobe;
  logic [PTRW-1:0] headIdx;
  logic [PTRW-1:0] tailIdx;
  logic [CNTW-1:0] count;

  stq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .wrReady(wrReady),
    .enqReady(enqReady), .wrValid(wrValid), .bufFull(bufFull), .bufEmpty(bufEmpty),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx), .count(count)
  );

  stq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .count(count), .enqAddr(enqAddr), .enqData(enqData), .enqBe(enqBe),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldBe(ldBe), .fwdData(fwdData),
    .fwdMask(fwdMask), .fwdHit(fwdHit), .ldStall(ldStall),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe)
  );
endmodule

// File: tb/tb_commit_store_queue.sv
module tb_commit_store_queue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic enqValid = 0, ldValid = 0, wrReady = 0;
  logic [31:0] enqAddr = 0, enqData = 0, ldAddr = 0;
  logic [3:0]  enqBe = 0, ldBe = 0;
  logic enqReady, fwdHit, ldStall, wrValid, bufFull, bufEmpty;
  logic [31:0] fwdData, wrAddr, wrData;
  logic [3:0]  fwdMask, wrBe;

  commit_store_queue dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of accepted stores, in acceptance order
  logic [31:0] mAddr [16];
  logic [31:0] mData [16];
  logic [3:0]  mBe   [16];
  int mWr = 0, mRd = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    enqValid = 1; enqAddr = a; enqData = d; enqBe = be;
    @(posedge clk);
    mAddr[mWr] = a; mData[mWr] = d; mBe[mWr] = be; mWr++;
    @(negedge clk);
    enqValid = 0;
  endtask

  // {ldValid, addr, be, expData, expMask, expHit, expStall}
  localparam int NV = 8;
  localparam logic [74:0] LOOKUPS [NV] = '{
    {1'b1, 32'h100, 4'hF, 32'h11EE3344, 4'hF, 1'b1, 1'b0},
    {1'b1, 32'h104, 4'h3, 32'h0000CCDD, 4'h3, 1'b1, 1'b0},
    {1'b1, 32'h104, 4'hF, 32'h0000CCDD, 4'h3, 1'b0, 1'b1},
    {1'b1, 32'h108, 4'h8, 32'h99000000, 4'h8, 1'b1, 1'b0},
    {1'b1, 32'h108, 4'h1, 32'h00000000, 4'h0, 1'b0, 1'b0},
    {1'b1, 32'h10C, 4'hF, 32'h00000000, 4'h0, 1'b0, 1'b0},
    {1'b0, 32'h100, 4'hF, 32'h00000000, 4'h0, 1'b0, 1'b0},
    {1'b1, 32'h100, 4'h4, 32'h00EE0000, 4'h4, 1'b1, 1'b0}
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset state
    chk(bufEmpty && !bufFull && enqReady && !wrValid, "R1 reset flags",
        {28'd0, bufEmpty, bufFull, enqReady, wrValid}, 32'hA);

    push(32'h100, 32'h11223344, 4'hF);
    #1;
    // R3 head shown on write port
    chk(wrValid && wrAddr == 32'h100 && wrData == 32'h11223344 && wrBe == 4'hF,
        "R3 head on write port", wrAddr, 32'h100);
    // R10
    chk(!bufEmpty, "R10 not empty after accept", {31'd0, bufEmpty}, 0);
    push(32'h104, 32'hAABBCCDD, 4'h3);
    push(32'h100, 32'h00EE0000, 4'h4);
    push(32'h108, 32'h99887766, 4'h8);
    #1;
    // R4 held while wrReady low
    chk(wrAddr == 32'h100 && wrData == 32'h11223344, "R4 write port stable", wrAddr, 32'h100);

    // R6 R7 R8 lookup table
    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = LOOKUPS[i];
      @(negedge clk);
      ldValid = v[74]; ldAddr = v[73:42]; ldBe = v[41:38];
      #1;
      chk(fwdData == v[37:6], "R6 forwarded data", fwdData, v[37:6]);
      chk(fwdMask == v[5:2], "R6 forwarded mask", {28'd0, fwdMask}, {28'd0, v[5:2]});
      chk(fwdHit == v[1], "R7 full hit", {31'd0, fwdHit}, {31'd0, v[1]});
      chk(ldStall == v[0], "R7 R8 partial stall", {31'd0, ldStall}, {31'd0, v[0]});
    end
    @(negedge clk); ldValid = 0;

    for (int k = 4; k < 8; k++) push(32'h110 + 32'(4*(k-4)), 32'hC0DE0000 + 32'(k), 4'hF);
    #1;
    // R2 full
    chk(bufFull && !enqReady, "R2 full blocks accept", {30'd0, bufFull, enqReady}, 32'h2);

    // R5 store while full is dropped
    @(negedge clk);
    enqValid = 1; enqAddr = 32'h200; enqData = 32'hDEADBEEF; enqBe = 4'hF;
    @(negedge clk); enqValid = 0;
    #1;
    chk(bufFull && wrAddr == 32'h100, "R5 dropped store no effect", wrAddr, 32'h100);

    // drain one alone
    @(negedge clk); wrReady = 1;
    #1; chk(wrAddr == mAddr[mRd] && wrData == mData[mRd] && wrBe == mBe[mRd], "R3 drain order", wrAddr, mAddr[mRd]);
    @(posedge clk); mRd++;
    @(negedge clk); wrReady = 0;
    #1; chk(!bufFull && enqReady, "R2 space after drain", {30'd0, bufFull, enqReady}, 32'h1);

    // R9 accept and drain together
    @(negedge clk);
    wrReady = 1; enqValid = 1; enqAddr = 32'h300; enqData = 32'h30303030; enqBe = 4'hF;
    #1; chk(wrAddr == mAddr[mRd], "R3 drain order", wrAddr, mAddr[mRd]);
    @(posedge clk);
    mAddr[mWr] = 32'h300; mData[mWr] = 32'h30303030; mBe[mWr] = 4'hF; mWr++; mRd++;
    @(negedge clk); wrReady = 0; enqValid = 0;
    #1; chk(!bufFull && !bufEmpty, "R9 flags unchanged", {30'd0, bufFull, bufEmpty}, 0);
    push(32'h304, 32'h31313131, 4'h5);
    #1; chk(bufFull, "R9 occupancy kept", {31'd0, bufFull}, 1);

    // drain all remaining
    while (mRd < mWr) begin
      @(negedge clk); wrReady = 1;
      #1;
      chk(wrValid && wrAddr == mAddr[mRd] && wrData == mData[mRd] && wrBe == mBe[mRd],
          "R3 R5 drain order", wrAddr, mAddr[mRd]);
      @(posedge clk); mRd++;
    end
    @(negedge clk); wrReady = 0;
    #1;
    chk(bufEmpty && !wrValid, "R10 empty after drain", {30'd0, bufEmpty, wrValid}, 32'h2);
    chk(mRd == 10, "R3 write count", 32'(mRd), 32'd10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule